// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block keeps recently used linear-to-physical page translations, so a memory access that hits needs no table reads. It holds 32 translations of 4 KB pages, 128 KB of address space in all, in 8 sets of 4 ways. A lookup presents a 20-bit virtual page number. In the same cycle the block answers with a hit flag, the physical frame number and the stored user, writable and dirty bits. On a miss the external page walker reads the tables. It then loads the result through the fill port, and the entry can be looked up from the next cycle on.

A write that hits an entry whose dirty bit is clear is reported as a miss. The walker then sets the dirty bit in memory and refills the entry. Writing the page directory base register raises the flush input, which empties the whole buffer in one cycle. A separate invalidate request carries a full linear address and removes only the entry for that page.

Top module: `pagexlat_tlb`

## Requirements
- R1: The buffer holds 32 translations in 8 sets of 4 ways. The set is chosen by virtual page number bits 2:0 and the tag is bits 19:3. After reset no lookup hits.
- R2: A lookup answers combinationally in the cycle it is presented: hit, frame and attributes. When the result is not a hit, or no lookup is requested, the frame, user, writable and dirty outputs are all zero.
- R3: A fill is visible to lookups from the cycle after it. A fill for a page already held in its set overwrites that entry in place, so the page never occupies two ways.
- R4: A fill for a new page takes the lowest-numbered invalid way of its set whenever one exists, so no held entry is evicted.
- R5: In a full set, a fill replaces the way picked by a 3-bit tree pseudo-LRU. The root bit selects ways 0-1 when 0 and ways 2-3 when 1. Each leaf bit selects the lower way of its pair when 0. Using a way turns every bit on its path away from that way.
- R6: A write lookup that matches an entry with the dirty bit clear reports a miss. A write lookup that matches a dirty entry hits.
- R7: A flush makes every entry invalid at the next clock edge. A fill in the same cycle as a flush is discarded.
- R8: An invalidate request takes the page number from bits 31:12 of its linear address. It removes only the entry that matches that page and leaves every other entry, including others in the same set, untouched. It has no effect when no entry matches.
- R9: Only lookups that report a hit, and fills, update the replacement state. A write lookup that is reported as a miss leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found and usable |
| lk_pfn | output | 20 | Physical frame number on a hit |
| lk_user | output | 1 | User-accessible bit on a hit |
| lk_writable | output | 1 | Writable bit on a hit |
| lk_dirty | output | 1 | Dirty bit on a hit |
| fill_valid | input | 1 | Load an entry from the walker |
| fill_vpn | input | 20 | Page number of the entry loaded |
| fill_pfn | input | 20 | Frame number of the entry loaded |
| fill_user | input | 1 | User bit of the entry loaded |
| fill_writable | input | 1 | Writable bit of the entry loaded |
| fill_dirty | input | 1 | Dirty bit of the entry loaded |
| flush_all | input | 1 | Directory base written: drop every entry |
| inv_valid | input | 1 | Drop the entry for one page |
| inv_addr | input | 32 | Linear address of the page to drop |

## Verification
The properties assume that a lookup is never issued in the same cycle as a flush, fill or invalidate. They also assume the walker never fills a page while an invalidate for the same page is pending. The bench applies exactly one operation per cycle and drops every input back to idle between operations, so these assumptions always hold. The reset-state checks are made only after the reset release, and the bench leaves the request inputs low while reset is active, so the first-cycle history the checker samples is idle.

// File: rtl/pagexlat_tlb.sv
module pagexlat_tlb #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_user,
  output logic             lk_writable,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_user,
  input  logic             fill_writable,
  input  logic             fill_dirty,
  input  logic             flush_all,
  input  logic             inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFF_W = ADDR_W - VPN_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PFN_W-1:0] pfn_q [SETS][WAYS];
  logic [2:0]       att_q [SETS][WAYS];
  logic [2:0]       plru_q [SETS];

  function automatic logic [2:0] plru_touch(logic [2:0] b, logic [WAY_W-1:0] w);
    logic [2:0] n;
    n    = b;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  wire [SET_W-1:0] lk_set   = lk_vpn[SET_W-1:0];
  wire [TAG_W-1:0] lk_tag   = lk_vpn[VPN_W-1:SET_W];
  wire [SET_W-1:0] fill_set = fill_vpn[SET_W-1:0];
  wire [TAG_W-1:0] fill_tag = fill_vpn[VPN_W-1:SET_W];
  wire [VPN_W-1:0] inv_vpn  = inv_addr[ADDR_W-1:OFF_W];
  wire [SET_W-1:0] inv_set  = inv_vpn[SET_W-1:0];
  wire [TAG_W-1:0] inv_tag  = inv_vpn[VPN_W-1:SET_W];

  logic [WAYS-1:0]  way_match, fill_match, inv_match;
  logic [WAY_W-1:0] hit_way, fill_way;
  logic [2:0]       hit_att;
  logic [PFN_W-1:0] hit_pfn;
  logic             any_match, fill_free;

  always_comb begin
    hit_way   = '0;
    fill_way  = plru_victim(plru_q[fill_set]);
    fill_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      way_match[w]  = vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag;
      fill_match[w] = vld_q[fill_set][w] && tag_q[fill_set][w] == fill_tag;
      inv_match[w]  = vld_q[inv_set][w] && tag_q[inv_set][w] == inv_tag;
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) hit_way = WAY_W'(w);
      if (!vld_q[fill_set][w]) begin
        fill_way  = WAY_W'(w);
        fill_free = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++)
      if (fill_match[w]) fill_way = WAY_W'(w);
  end

  assign any_match   = |way_match;
  assign hit_att     = att_q[lk_set][hit_way];
  assign hit_pfn     = pfn_q[lk_set][hit_way];
  assign lk_hit      = lk_valid && any_match && !(lk_write && !hit_att[0]);
  assign lk_pfn      = lk_hit ? hit_pfn : '0;
  assign lk_user     = lk_hit && hit_att[2];
  assign lk_writable = lk_hit && hit_att[1];
  assign lk_dirty    = lk_hit && hit_att[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (flush_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (lk_hit) plru_q[lk_set] <= plru_touch(plru_q[lk_set], hit_way);
      if (inv_valid) vld_q[inv_set] <= vld_q[inv_set] & ~inv_match;
      if (fill_valid) begin
        vld_q[fill_set][fill_way] <= 1'b1;
        plru_q[fill_set] <= plru_touch(plru_q[fill_set], fill_way);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !flush_all) begin
      tag_q[fill_set][fill_way] <= fill_tag;
      pfn_q[fill_set][fill_way] <= fill_pfn;
      att_q[fill_set][fill_way] <= {fill_user, fill_writable, fill_dirty};
    end
  end

  logic unused_free;
  assign unused_free = fill_free;
endmodule

module pagexlat_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_write,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              lk_hit,
  input logic [PFN_W-1:0]  lk_pfn,
  input logic              lk_user,
  input logic              lk_writable,
  input logic              lk_dirty,
  input logic              fill_valid,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [PFN_W-1:0]  fill_pfn,
  input logic              flush_all,
  input logic              inv_valid,
  input logic [ADDR_W-1:0] inv_addr,
  input logic [WAYS-1:0]   way_match
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0 && !lk_user && !lk_writable && !lk_dirty)); // R2
  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match)); // R3
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(fill_valid && !flush_all && !inv_valid) && lk_valid && !lk_write
     && lk_vpn == $past(fill_vpn)) |-> (lk_hit && lk_pfn == $past(fill_pfn))); // R3
  AST_WRITE_CLEAN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_write && lk_hit) |-> lk_dirty); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit); // R7
  AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(inv_valid && !fill_valid) && lk_valid
     && lk_vpn == $past(inv_addr[ADDR_W-1:ADDR_W-VPN_W])) |-> !lk_hit); // R8
endmodule

bind pagexlat_tlb pagexlat_tlb_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .WAYS(WAYS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_user(lk_user),
  .lk_writable(lk_writable), .lk_dirty(lk_dirty), .fill_valid(fill_valid),
  .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .flush_all(flush_all),
  .inv_valid(inv_valid), .inv_addr(inv_addr), .way_match(way_match)
);

// File: tb/sim_pagexlat_tlb.sv
`timescale 1ns/1ps
module sim_pagexlat_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0;
  logic [19:0] lk_vpn = '0;
  logic lk_hit, lk_user, lk_writable, lk_dirty;
  logic [19:0] lk_pfn;
  logic fill_valid = 0, fill_user = 0, fill_writable = 0, fill_dirty = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic flush_all = 0, inv_valid = 0;
  logic [31:0] inv_addr = '0;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  pagexlat_tlb u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_user(lk_user),
    .lk_writable(lk_writable), .lk_dirty(lk_dirty), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_user(fill_user),
    .fill_writable(fill_writable), .fill_dirty(fill_dirty),
    .flush_all(flush_all), .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  localparam logic [2:0] LK = 0, FL = 1, IV = 2, FS = 3, FF = 4;

  function automatic logic [51:0] mkv(logic [2:0] op, logic wr, logic [19:0] vpn,
      logic [19:0] pfn, logic [2:0] att, logic eh, logic [3:0] rq);
    return {op, wr, vpn, pfn, att, eh, rq};
  endfunction

  localparam int NV = 34;
  localparam logic [51:0] TBL [NV] = '{
    mkv(FL, 0, 20'h00010, 20'h11111, 3'b110, 0, 3),  // R3 fill A
    mkv(LK, 0, 20'h00010, 20'h11111, 3'b110, 1, 2),  // R2 read hit
    mkv(LK, 1, 20'h00010, 20'h00000, 3'b000, 0, 6),  // R6 write to clean
    mkv(FL, 0, 20'h00010, 20'h11111, 3'b111, 0, 3),  // R3 refill in place
    mkv(LK, 1, 20'h00010, 20'h11111, 3'b111, 1, 6),  // R6 write to dirty
    mkv(FL, 0, 20'h00020, 20'h22222, 3'b000, 0, 5),
    mkv(FL, 0, 20'h00030, 20'h33333, 3'b010, 0, 5),
    mkv(FL, 0, 20'h00040, 20'h44444, 3'b100, 0, 5),
    mkv(LK, 0, 20'h00010, 20'h11111, 3'b111, 1, 5),  // R5 touch way0
    mkv(FL, 0, 20'h00050, 20'h55555, 3'b001, 0, 5),  // R5 evicts C
    mkv(LK, 0, 20'h00030, 20'h00000, 3'b000, 0, 5),  // R5 C gone
    mkv(LK, 1, 20'h00020, 20'h00000, 3'b000, 0, 9),  // R9 clean write miss
    mkv(FL, 0, 20'h00060, 20'h66666, 3'b011, 0, 9),  // R9 evicts B
    mkv(LK, 0, 20'h00020, 20'h00000, 3'b000, 0, 9),
    mkv(LK, 0, 20'h00010, 20'h11111, 3'b111, 1, 9),
    mkv(LK, 0, 20'h00040, 20'h44444, 3'b100, 1, 9),
    mkv(LK, 0, 20'h00060, 20'h66666, 3'b011, 1, 9),
    mkv(LK, 0, 20'h00050, 20'h55555, 3'b001, 1, 5),
    mkv(IV, 0, 20'h00040, 20'h00000, 3'b000, 0, 8),  // R8 drop D
    mkv(LK, 0, 20'h00040, 20'h00000, 3'b000, 0, 8),
    mkv(LK, 0, 20'h00050, 20'h55555, 3'b001, 1, 8),  // R8 set-mate kept
    mkv(IV, 0, 20'h00080, 20'h00000, 3'b000, 0, 8),  // R8 no match
    mkv(FL, 0, 20'h00070, 20'h77777, 3'b010, 0, 4),  // R4 into freed way
    mkv(LK, 0, 20'h00010, 20'h11111, 3'b111, 1, 4),
    mkv(LK, 0, 20'h00070, 20'h77777, 3'b010, 1, 4),
    mkv(LK, 0, 20'h00060, 20'h66666, 3'b011, 1, 4),
    mkv(LK, 0, 20'h00050, 20'h55555, 3'b001, 1, 4),
    mkv(FS, 0, 20'h00000, 20'h00000, 3'b000, 0, 7),  // R7 flush
    mkv(LK, 0, 20'h00010, 20'h00000, 3'b000, 0, 7),
    mkv(FF, 0, 20'h00123, 20'habcde, 3'b110, 0, 7),  // R7 flush beats fill
    mkv(LK, 0, 20'h00123, 20'h00000, 3'b000, 0, 7),
    mkv(FL, 0, 20'hfffff, 20'h00001, 3'b100, 0, 1),  // R1 set 7
    mkv(LK, 0, 20'hfffff, 20'h00001, 3'b100, 1, 1),
    mkv(LK, 0, 20'h7ffff, 20'h00000, 3'b000, 0, 1)   // R1 tag bit 19 differs
  };

  task automatic check(string rq, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    lk_valid = 0; lk_write = 0; fill_valid = 0; flush_all = 0; inv_valid = 0;
  endtask

  task automatic do_fill(logic [19:0] v, logic [19:0] p, logic [2:0] a);
    fill_valid = 1; fill_vpn = v; fill_pfn = p;
    {fill_user, fill_writable, fill_dirty} = a;
    step();
  endtask

  task automatic do_look(logic [19:0] v, logic wr, output logic [23:0] res);
    lk_valid = 1; lk_write = wr; lk_vpn = v;
    #1;
    res = {lk_hit, lk_user, lk_writable, lk_dirty, lk_pfn};
    step();
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [23:0] r;
    int hits;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    do_look(20'h00010, 0, r);
    check("R1 reset empty", r, 24'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic wr, eh; logic [19:0] vpn, pfn; logic [2:0] att; logic [3:0] rq;
      {op, wr, vpn, pfn, att, eh, rq} = TBL[i];
      case (op)
        LK: begin
          do_look(vpn, wr, r);
          check($sformatf("R%0d vec %0d", rq, i), r, eh ? {1'b1, att, pfn} : 24'h0);
        end
        FL: do_fill(vpn, pfn, att);
        IV: begin inv_valid = 1; inv_addr = {vpn, 12'h5a5}; step(); end
        FS: begin flush_all = 1; step(); end
        default: begin flush_all = 1; fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; step(); end
      endcase
    end

    lk_valid = 0; lk_vpn = 20'hfffff; #1;
    check("R2 no request", {lk_hit, lk_user, lk_writable, lk_dirty, lk_pfn}, 24'h0);

    flush_all = 1; step();
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 8; s++)
        do_fill(20'((k + 1) * 8 + s), 20'((k + 1) * 8 + s) ^ 20'h50000, 3'b001);
    hits = 0;
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 8; s++) begin
        do_look(20'((k + 1) * 8 + s), 0, r);
        if (r === {4'b1001, 20'((k + 1) * 8 + s) ^ 20'h50000}) hits++;
      end
    check("R1 32 entries held", 24'(hits), 24'd32);
    do_fill(20'h00405, 20'h00405, 3'b000);
    hits = 0;
    for (int k = 0; k < 4; k++) begin
      do_look(20'((k + 1) * 8 + 5), 0, r);
      if (r[23]) hits++;
    end
    do_look(20'h00405, 0, r);
    if (r[23]) hits++;
    check("R5 one eviction in full set", 24'(hits), 24'd4);

    rst_n = 0; #1; rst_n = 1; #1;
    do_look(20'h00405, 0, r);
    check("R1 reset clears", r, 24'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule